// File: doc/BRIEF.md
# Link-to-Memory Burst Staging Buffer

This block sits between a byte-wide serial link interface and a 64-bit memory port that works in four-beat bursts. The receive path and the transmit path are independent. Each has its own staging word on the link side, its own four-word burst buffer and its own memory request and acknowledge pair.

On receive, link bytes are packed into a 64-bit assembly word. Each completed word moves into the burst buffer. Once the buffer holds 32 bytes, the block requests a write burst. On transmit, the block requests a read burst whenever its burst buffer is empty. It stores the four returned beats and feeds the link one byte at a time through a 64-bit staging word.

Because each direction has two stages, the link keeps moving data while the memory port is held by other masters. The memory port, in turn, only ever sees complete four-beat bursts.

Top module: `link_burst_stage`

## Requirements
- R1: Received bytes are packed with the first accepted byte in bits [7:0] of a word. Byte n of a word lands in bits [8n+7:8n], and bytes 0 to 7 of the stream form word 0.
- R2: `wr_req_o` goes high at the clock edge right after the edge that accepts the 32nd byte of a burst, and not before.
- R3: While `wr_req_o` is high, each cycle with `wr_ack_ni` low consumes exactly one beat. `wr_data_o` shows the words in arrival order, and a cycle with `wr_ack_ni` high consumes nothing.
- R4: `wr_req_o` stays high until the fourth acknowledged beat and drops at that beat's clock edge.
- R5: `rx_ready_o` is high whenever `wr_req_o` is low. While a write burst is pending, eight more bytes are still accepted. After that, `rx_ready_o` stays low until the burst is acknowledged, and no byte is lost or duplicated.
- R6: `rd_req_o` rises at the first clock edge after reset release. It also rises whenever the transmit burst buffer is empty. It stays high through unacknowledged cycles and drops at the edge of the fourth acknowledged beat.
- R7: Read beats are stored in order. The link receives each word least significant byte first, in word order.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` stays unchanged.
- R9: The next read request is issued at the edge where the last stored word enters the staging word. `rd_req_o` is therefore already high when byte 24 of a burst (the first byte of the fourth word) appears on the link.
- R10: Reset (`rst_ni` low) clears both request outputs, `tx_valid_o` and all partial assembly state. After release, `rx_ready_o` is high, and a fresh stream packs from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received link byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Block can accept a received byte |
| wr_req_o | output | 1 | Write burst request to memory |
| wr_ack_ni | input | 1 | Write beat acknowledge, active low |
| wr_data_o | output | 64 | Write beat data |
| rd_req_o | output | 1 | Read burst request to memory |
| rd_ack_ni | input | 1 | Read beat acknowledge, active low |
| rd_data_i | input | 64 | Read beat data |
| tx_data_o | output | 8 | Byte to the link |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Link takes the byte |

## Verification
The write request is due one edge after the 32nd byte is accepted. The bench therefore samples it low at the first falling edge after that acceptance and high at the second. Beat data and both requests change only at the edge that consumes an acknowledged beat, so each beat's data is checked at the falling edge where the acknowledge is driven. The dropped request is checked at the falling edge that follows the fourth beat. Transmit bytes change one edge after being taken, so each byte is compared at the next falling edge, and the prefetch request is checked when byte 24 is on the link.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned WORD_W      = 64;
  localparam int unsigned LANES       = WORD_W / BYTE_W;
  localparam int unsigned BURST_BEATS = 4;
  typedef logic [BYTE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/lbs_rx_pack.sv
module lbs_rx_pack
  import lbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  lane_t byte_i,
  input  logic  byte_valid_i,
  output logic  byte_ready_o,
  input  logic  space_i,
  output logic  push_o,
  output word_t word_o
);
  localparam int unsigned LW = $clog2(LANES);

  logic [LW-1:0] lane_q;
  word_t         asm_q;
  logic          full_q;
  logic          accept;
  logic          last;

  assign push_o       = full_q & space_i;
  assign byte_ready_o = ~full_q | push_o;
  assign accept       = byte_valid_i & byte_ready_o;
  assign last         = lane_q == LW'(LANES - 1);
  assign word_o       = asm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      asm_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) begin
        asm_q[lane_q*BYTE_W +: BYTE_W] <= byte_i;
        lane_q <= last ? '0 : lane_q + 1'b1;
      end
      if (accept && last) full_q <= 1'b1;
      else if (push_o)    full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lbs_rx_burst.sv
module lbs_rx_burst
  import lbs_pkg::*;
#(
  parameter int unsigned BURST = BURST_BEATS
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  word_t word_i,
  output logic  space_o,
  output logic  req_o,
  input  logic  ack_ni,
  output word_t data_o
);
  localparam int unsigned CW = $clog2(BURST + 1);
  localparam int unsigned IW = (BURST > 1) ? $clog2(BURST) : 1;

  word_t         mem_q [BURST];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] beat_q;
  logic          full;
  logic          beat;

  assign full    = cnt_q == CW'(BURST);
  assign req_o   = full;
  assign space_o = ~full;
  assign beat    = full & ~ack_ni;
  assign data_o  = mem_q[beat_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BURST; i++) mem_q[i] <= '0;
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      if (push_i && !full) begin
        mem_q[cnt_q[IW-1:0]] <= word_i;
        cnt_q <= cnt_q + 1'b1;
      end
      if (beat) begin
        if (beat_q == IW'(BURST - 1)) begin
          beat_q <= '0;
          cnt_q  <= '0;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lbs_tx_burst.sv
module lbs_tx_burst
  import lbs_pkg::*;
#(
  parameter int unsigned BURST = BURST_BEATS
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  output logic  req_o,
  input  logic  ack_ni,
  input  word_t data_i,
  output word_t word_o,
  output logic  avail_o,
  input  logic  pop_i
);
  localparam int unsigned CW = $clog2(BURST + 1);
  localparam int unsigned IW = (BURST > 1) ? $clog2(BURST) : 1;

  word_t         mem_q [BURST];
  logic [CW-1:0] have_q, have_n;
  logic [IW-1:0] rptr_q, wptr_q;
  logic          req_q;
  logic          beat;
  logic          done;
  logic          pop;

  assign beat    = req_q & ~ack_ni;
  assign done    = beat & (wptr_q == IW'(BURST - 1));
  assign avail_o = have_q != '0;
  assign pop     = pop_i & avail_o;
  assign word_o  = mem_q[rptr_q];
  assign req_o   = req_q;

  always_comb begin
    if (done)     have_n = CW'(BURST);
    else if (pop) have_n = have_q - 1'b1;
    else          have_n = have_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BURST; i++) mem_q[i] <= '0;
      have_q <= '0;
      rptr_q <= '0;
      wptr_q <= '0;
      req_q  <= 1'b0;
    end else begin
      have_q <= have_n;
      req_q  <= have_n == '0;
      if (beat) begin
        mem_q[wptr_q] <= data_i;
        wptr_q <= done ? '0 : wptr_q + 1'b1;
      end
      if (done)     rptr_q <= '0;
      else if (pop) rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/lbs_tx_unpack.sv
module lbs_tx_unpack
  import lbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t word_i,
  input  logic  avail_i,
  output logic  pop_o,
  output lane_t byte_o,
  output logic  valid_o,
  input  logic  ready_i
);
  localparam int unsigned LW = $clog2(LANES);

  word_t         stg_q;
  logic [LW-1:0] lane_q;
  logic          vld_q;
  logic          take;
  logic          drained;

  assign take    = vld_q & ready_i;
  assign drained = take & (lane_q == LW'(LANES - 1));
  assign pop_o   = avail_i & (~vld_q | drained);
  assign byte_o  = stg_q[lane_q*BYTE_W +: BYTE_W];
  assign valid_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      lane_q <= '0;
      vld_q  <= 1'b0;
    end else if (pop_o) begin
      stg_q  <= word_i;
      lane_q <= '0;
      vld_q  <= 1'b1;
    end else if (drained) begin
      lane_q <= '0;
      vld_q  <= 1'b0;
    end else if (take) begin
      lane_q <= lane_q + 1'b1;
    end
  end
endmodule

// File: rtl/link_burst_stage.sv
module link_burst_stage
  import lbs_pkg::*;
#(
  parameter int unsigned BURST = BURST_BEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              wr_req_o,
  input  logic              wr_ack_ni,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              rd_req_o,
  input  logic              rd_ack_ni,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  logic  rx_push, rx_space;
  word_t rx_word;
  logic  tx_avail, tx_pop;
  word_t tx_word;

  lbs_rx_pack u_rx_pack (
    .clk_i, .rst_ni,
    .byte_i(rx_data_i), .byte_valid_i(rx_valid_i), .byte_ready_o(rx_ready_o),
    .space_i(rx_space), .push_o(rx_push), .word_o(rx_word)
  );

  lbs_rx_burst #(.BURST(BURST)) u_rx_burst (
    .clk_i, .rst_ni,
    .push_i(rx_push), .word_i(rx_word), .space_o(rx_space),
    .req_o(wr_req_o), .ack_ni(wr_ack_ni), .data_o(wr_data_o)
  );

  lbs_tx_burst #(.BURST(BURST)) u_tx_burst (
    .clk_i, .rst_ni,
    .req_o(rd_req_o), .ack_ni(rd_ack_ni), .data_i(rd_data_i),
    .word_o(tx_word), .avail_o(tx_avail), .pop_i(tx_pop)
  );

  lbs_tx_unpack u_tx_unpack (
    .clk_i, .rst_ni,
    .word_i(tx_word), .avail_i(tx_avail), .pop_o(tx_pop),
    .byte_o(tx_data_o), .valid_o(tx_valid_o), .ready_i(tx_ready_i)
  );
endmodule

// File: rtl/link_burst_stage_chk.sv
module link_burst_stage_chk
  import lbs_pkg::*;
#(
  parameter int unsigned BURST = BURST_BEATS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] rx_data_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              wr_req_o,
  input logic              wr_ack_ni,
  input logic [WORD_W-1:0] wr_data_o,
  input logic              rd_req_o,
  input logic              rd_ack_ni,
  input logic [WORD_W-1:0] rd_data_i,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i
);
  localparam int unsigned IW = (BURST > 1) ? $clog2(BURST) : 1;

  logic [IW-1:0] wr_beats_q, rd_beats_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_beats_q <= '0;
      rd_beats_q <= '0;
    end else begin
      if (wr_req_o && !wr_ack_ni)
        wr_beats_q <= (wr_beats_q == IW'(BURST - 1)) ? '0 : wr_beats_q + 1'b1;
      if (rd_req_o && !rd_ack_ni)
        rd_beats_q <= (rd_beats_q == IW'(BURST - 1)) ? '0 : rd_beats_q + 1'b1;
    end
  end

  // R5
  rx_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_o |-> rx_ready_o);

  // R4
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_ni |=> wr_req_o);

  // R4
  wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_ni && wr_beats_q == IW'(BURST - 1) |=> !wr_req_o);

  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_ni |=> rd_req_o);

  // R6
  rd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_ni && rd_beats_q == IW'(BURST - 1) |=> !rd_req_o);

  // R8
  tx_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
endmodule

bind link_burst_stage link_burst_stage_chk #(.BURST(BURST)) u_chk (.*);

// File: tb/tb_link_burst_stage.sv
`timescale 1ns/1ps
module tb_link_burst_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        wr_req;
  logic        wr_ack_n = 1'b1;
  logic [63:0] wr_data;
  logic        rd_req;
  logic        rd_ack_n = 1'b1;
  logic [63:0] rd_data = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  link_burst_stage dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .wr_req_o(wr_req), .wr_ack_ni(wr_ack_n), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_ack_ni(rd_ack_n), .rd_data_i(rd_data),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready)
  );

  // {seed, step, gap}: byte n of a stream = seed + n*step
  localparam logic [16:0] VEC [5] = '{
    {8'h00, 8'h01, 1'b0}, {8'hA5, 8'h03, 1'b1}, {8'h3C, 8'h11, 1'b0},
    {8'hFF, 8'h07, 1'b1}, {8'h5A, 8'hC3, 1'b0}
  };

  function automatic logic [7:0] gen(input logic [7:0] s, input logic [7:0] t, input int n);
    return 8'(s + 8'(n) * t);
  endfunction

  function automatic logic [63:0] genw(input logic [7:0] s, input logic [7:0] t, input int j);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = gen(s, t, 8*j + k);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    #0.5;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    #0.5 rx_valid = 1'b0;
  endtask

  // called right after the edge that accepted the 32nd byte of a burst
  task automatic wr_expect_req();
    @(negedge clk);
    chk(wr_req == 1'b0, "R2 early", 64'(wr_req), 64'd0);
    @(negedge clk);
    chk(wr_req == 1'b1, "R2 due", 64'(wr_req), 64'd1);
  endtask

  task automatic wr_drain(input logic [7:0] s, input logic [7:0] t, input int jb, input bit gap);
    for (int k = 0; k < 4; k++) begin
      wr_ack_n = 1'b0;
      #0.5;
      chk(wr_data == genw(s, t, jb + k), "R1 R3 beat data", wr_data, genw(s, t, jb + k));
      chk(wr_req == 1'b1, "R4 held", 64'(wr_req), 64'd1);
      @(negedge clk);
      if (gap && k == 1) begin
        wr_ack_n = 1'b1;
        #0.5;
        chk(wr_data == genw(s, t, jb + 2), "R3 idle cycle", wr_data, genw(s, t, jb + 2));
        @(negedge clk);
        chk(wr_req == 1'b1, "R4 hold", 64'(wr_req), 64'd1);
      end
    end
    wr_ack_n = 1'b1;
    chk(wr_req == 1'b0, "R4 drop", 64'(wr_req), 64'd0);
  endtask

  task automatic rd_supply(input logic [7:0] s, input logic [7:0] t, input bit gap);
    @(negedge clk);
    while (!rd_req) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      rd_ack_n = 1'b0;
      rd_data  = genw(s, t, j);
      @(negedge clk);
      if (gap && j == 1) begin
        rd_ack_n = 1'b1;
        rd_data  = '1;
        @(negedge clk);
        chk(rd_req == 1'b1, "R6 hold", 64'(rd_req), 64'd1);
      end
    end
    rd_ack_n = 1'b1;
    rd_data  = '0;
    chk(rd_req == 1'b0, "R6 drop", 64'(rd_req), 64'd0);
  endtask

  task automatic tx_take(input logic [7:0] s, input logic [7:0] t);
    tx_ready = 1'b1;
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      while (!tx_valid) @(negedge clk);
      chk(tx_data == gen(s, t, n), "R7 tx byte", 64'(tx_data), 64'(gen(s, t, n)));
      if (n == 24) chk(rd_req == 1'b1, "R9 prefetch", 64'(rd_req), 64'd1);
      if (n == 10) begin
        tx_ready = 1'b0;
        for (int c = 0; c < 3; c++) begin
          @(negedge clk);
          chk(tx_valid && tx_data == gen(s, t, 10), "R8 stall", 64'(tx_data), 64'(gen(s, t, 10)));
        end
        tx_ready = 1'b1;
      end
    end
    @(posedge clk);
    #0.5 tx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(wr_req == 1'b0, "R10 wr_req in reset", 64'(wr_req), 64'd0);
    chk(rd_req == 1'b0, "R10 rd_req in reset", 64'(rd_req), 64'd0);
    chk(tx_valid == 1'b0, "R10 tx_valid in reset", 64'(tx_valid), 64'd0);
    rst_n = 1'b1;
    #0.5;
    chk(rx_ready == 1'b1, "R10 rx_ready after reset", 64'(rx_ready), 64'd1);
    @(negedge clk);
    chk(rd_req == 1'b1, "R6 first request", 64'(rd_req), 64'd1);

    // vector table
    for (int v = 0; v < 5; v++) begin
      logic [7:0] s;
      logic [7:0] t;
      bit g;
      {s, t, g} = VEC[v];
      for (int n = 0; n < 32; n++) rx_send(gen(s, t, n));
      wr_expect_req();
      wr_drain(s, t, 0, g);
      fork
        rd_supply(s, t, g);
        tx_take(s, t);
      join
    end

    // R5 back-pressure: 40 bytes with memory held off
    for (int n = 0; n < 40; n++) rx_send(gen(8'h10, 8'h01, n));
    @(negedge clk);
    chk(rx_ready == 1'b0, "R5 stalled", 64'(rx_ready), 64'd0);
    chk(wr_req == 1'b1, "R5 pending", 64'(wr_req), 64'd1);
    rx_valid = 1'b1;
    rx_data  = 8'hEE;
    repeat (3) begin
      @(negedge clk);
      chk(rx_ready == 1'b0, "R5 still stalled", 64'(rx_ready), 64'd0);
    end
    rx_valid = 1'b0;
    wr_drain(8'h10, 8'h01, 0, 1'b0);
    for (int n = 40; n < 64; n++) rx_send(gen(8'h10, 8'h01, n));
    wr_expect_req();
    wr_drain(8'h10, 8'h01, 4, 1'b0);

    // R10 mid-stream reset discards partial bytes
    for (int n = 0; n < 5; n++) rx_send(8'hDD);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(rd_req == 1'b0, "R10 rd_req cleared", 64'(rd_req), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(tx_valid == 1'b0, "R10 tx_valid cleared", 64'(tx_valid), 64'd0);
    for (int n = 0; n < 32; n++) rx_send(gen(8'h21, 8'h05, n));
    wr_expect_req();
    wr_drain(8'h21, 8'h05, 0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule